// File: doc/BRIEF.md
# Prime-Modulus Multiplicative Random Generator

This block produces a stream of pseudo-random 16-bit values. It holds a 16-bit state. On each accepted step it replaces the state with the product of the state and a fixed multiplier, reduced modulo the prime 65521 (2^16 − 15). The modulus is prime and the state is never zero, so the sequence stays in 1..65520 and cannot collapse to zero. The reduction uses only adders, a constant multiply by 15 and one conditional subtract. It contains no divider.

A step is requested with a one-cycle strobe. The 32-bit product is registered, and the reduced result becomes the new state one cycle later. A valid flag is high for exactly one cycle when a fresh value is present. A separate strobe loads a user seed. Illegal seeds are replaced with 1. A bin index splits the 65520 possible values into N equal groups. The bin index is always aligned with the current value.

Top module: `mcg_rng`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the value output is 1 and the valid flag is 0.
- R2: A step request accepted at a clock edge makes the value equal (previous value × 17364) mod 65521 after the second following edge. The valid flag is 1 for exactly that one cycle.
- R3: The value output always lies in 1 to 65520 inclusive.
- R4: A step request that arrives while a step is in flight (the cycle after acceptance) is ignored. Under a strobe held high continuously, one step completes every two cycles.
- R5: A seed load in the range 1 to 65520 sets the value to the seed after the next edge and clears the valid flag.
- R6: A seed load of 0, or of 65521 or more, sets the value to 1.
- R7: A seed load takes priority over a step request in the same cycle. It also cancels any step in flight, so no valid pulse follows and the loaded seed stays in place.
- R8: The bin output equals floor((value − 1) × N / 65520) for the current value, with N = BINS (default 10).
- R9: Without a seed load or a completing step, the value holds its previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load-seed strobe |
| seed_in | input | 16 | Seed value, sanitised on load |
| step_req | input | 1 | Request one generator step |
| rnd_value | output | 16 | Current generator value |
| rnd_valid | output | 1 | One-cycle flag marking a freshly computed value |
| rnd_bin | output | $clog2(BINS) (4 by default) | Bin index of the current value |

## Verification
Two functions can coincide in one cycle. The first is a seed load arriving together with a step request. The second is a seed load arriving while a step is in flight, which collides with the completing write of the state. The bench provokes both by raising the seed strobe alongside the step strobe, and one cycle after a step is accepted. It judges the result with a behavioural model in which a load always wins and discards the pending step. The bench also keeps the step strobe high for long runs, so that the busy-cycle requests are presented and must be dropped.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

  localparam int unsigned MCG_W    = 16;
  localparam int unsigned MCG_MOD  = 65521;
  localparam int unsigned MCG_MULT = 17364;
  localparam int unsigned MCG_FOLD = (1 << MCG_W) - MCG_MOD;  // 15
  localparam int unsigned PROD_W   = 2 * MCG_W;

  // First fold: product = hi*2^16 + lo, with 2^16 == 15 (mod prime)
  function automatic logic [MCG_W+3:0] mcg_fold_a(input logic [PROD_W-1:0] p);
    logic [MCG_W+3:0] lo, hi;
    lo = (MCG_W+4)'(p[MCG_W-1:0]);
    hi = (MCG_W+4)'(p[PROD_W-1:MCG_W]);
    return lo + hi * (MCG_W+4)'(MCG_FOLD);
  endfunction

  // Second fold of the small excess above 16 bits
  function automatic logic [MCG_W:0] mcg_fold_b(input logic [MCG_W+3:0] f);
    logic [MCG_W:0] lo, hi;
    lo = (MCG_W+1)'(f[MCG_W-1:0]);
    hi = (MCG_W+1)'(f[MCG_W+3:MCG_W]);
    return lo + hi * (MCG_W+1)'(MCG_FOLD);
  endfunction

  // Full reduction of a product modulo the prime
  function automatic logic [MCG_W-1:0] mcg_reduce(input logic [PROD_W-1:0] p);
    logic [MCG_W:0] f;
    f = mcg_fold_b(mcg_fold_a(p));
    if (f >= (MCG_W+1)'(MCG_MOD)) f = f - (MCG_W+1)'(MCG_MOD);
    return f[MCG_W-1:0];
  endfunction

  // Illegal seeds (zero or not below the modulus) become one
  function automatic logic [MCG_W-1:0] mcg_clean(input logic [MCG_W-1:0] s);
    if (s == '0 || 32'(s) >= MCG_MOD) return MCG_W'(1);
    return s;
  endfunction

endpackage

// File: rtl/mcg_seed_clean.sv
module mcg_seed_clean
  import mcg_pkg::*;
(
  input  logic [MCG_W-1:0] seed_raw,
  output logic [MCG_W-1:0] seed_ok,
  output logic             seed_fixed
);
  assign seed_ok    = mcg_clean(seed_raw);
  assign seed_fixed = (seed_ok != seed_raw);

  always_comb begin
    if (!$isunknown(seed_raw)) begin
      p_seed_legal_r6: assert (seed_ok != '0 && 32'(seed_ok) < MCG_MOD)
        else $error("sanitised seed out of range");
    end
  end
endmodule

// File: rtl/mcg_modmul.sv
module mcg_modmul
  import mcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             kill,
  input  logic             start,
  input  logic [MCG_W-1:0] operand,
  output logic             busy,
  output logic             done,
  output logic [MCG_W-1:0] result
);
  logic [PROD_W-1:0] prod_q;
  logic              inflight_q;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      inflight_q <= 1'b0;
      prod_q     <= '0;
    end else if (start && !inflight_q) begin
      inflight_q <= 1'b1;
      prod_q     <= PROD_W'(operand) * PROD_W'(MCG_MULT);
    end else begin
      inflight_q <= 1'b0;
    end
  end

  assign busy   = inflight_q;
  assign done   = inflight_q;
  assign result = mcg_reduce(prod_q);

  p_result_lt_mod_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (32'(result) < MCG_MOD))
    else $error("reduced result not below modulus");

  p_busy_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy)
    else $error("step in flight longer than one cycle");
endmodule

// File: rtl/mcg_binner.sv
module mcg_binner
  import mcg_pkg::*;
#(
  parameter int unsigned BINS  = 10,
  localparam int unsigned BIN_W = (BINS > 1) ? $clog2(BINS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MCG_W-1:0] value,
  output logic [BIN_W-1:0] bin
);
  localparam int unsigned SPAN = MCG_MOD - 1;

  // Smallest (value-1) that reaches bin k: ceil(k*SPAN/BINS)
  function automatic int unsigned edge_of(input int unsigned k);
    return (k * SPAN + BINS - 1) / BINS;
  endfunction

  logic [MCG_W-1:0] offs;
  logic [BINS-1:0]  hit;

  assign offs   = value - MCG_W'(1);
  assign hit[0] = 1'b0;

  generate
    for (genvar k = 1; k < BINS; k++) begin : g_edge
      assign hit[k] = (32'(offs) >= edge_of(k));
    end
  endgenerate

  always_comb begin
    bin = '0;
    for (int i = 1; i < BINS; i++) begin
      if (hit[i]) bin = bin + BIN_W'(1);
    end
  end

  p_bin_max_r8: assert property (@(posedge clk) disable iff (rst)
    (32'(bin) < BINS))
    else $error("bin index out of range");
endmodule

// File: rtl/mcg_rng.sv
module mcg_rng
  import mcg_pkg::*;
#(
  parameter int unsigned BINS  = 10,
  localparam int unsigned BIN_W = (BINS > 1) ? $clog2(BINS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_load,
  input  logic [MCG_W-1:0] seed_in,
  input  logic             step_req,
  output logic [MCG_W-1:0] rnd_value,
  output logic             rnd_valid,
  output logic [BIN_W-1:0] rnd_bin
);
  logic [MCG_W-1:0] state_q;
  logic             valid_q;
  logic [MCG_W-1:0] seed_ok;
  logic             seed_fixed;
  logic             step_busy, step_done;
  logic [MCG_W-1:0] step_result;
  logic             step_take;
  logic             step_write;

  mcg_seed_clean u_clean (
    .seed_raw   (seed_in),
    .seed_ok    (seed_ok),
    .seed_fixed (seed_fixed)
  );

  assign step_take  = step_req && !step_busy && !seed_load;
  assign step_write = step_done && !seed_load;

  mcg_modmul u_mul (
    .clk     (clk),
    .rst     (rst),
    .kill    (seed_load),
    .start   (step_take),
    .operand (state_q),
    .busy    (step_busy),
    .done    (step_done),
    .result  (step_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MCG_W'(1);
      valid_q <= 1'b0;
    end else if (seed_load) begin
      state_q <= seed_ok;
      valid_q <= 1'b0;
    end else if (step_write) begin
      state_q <= step_result;
      valid_q <= 1'b1;
    end else begin
      valid_q <= 1'b0;
    end
  end

  mcg_binner #(.BINS(BINS)) u_bin (
    .clk   (clk),
    .rst   (rst),
    .value (state_q),
    .bin   (rnd_bin)
  );

  assign rnd_value = state_q;
  assign rnd_valid = valid_q;

  p_value_range_r3: assert property (@(posedge clk) disable iff (rst)
    (rnd_value != '0) && (32'(rnd_value) < MCG_MOD))
    else $error("value outside 1..65520");

  p_valid_after_take_r2: assert property (@(posedge clk) disable iff (rst)
    step_take ##1 !seed_load |=> rnd_valid)
    else $error("accepted step produced no valid pulse");

  p_valid_has_source_r2: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |-> $past(step_take, 2))
    else $error("valid pulse without an accepted step");

  p_load_sets_value_r5: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (!rnd_valid && rnd_value == $past(seed_ok)))
    else $error("seed load not applied");

  p_load_cancels_r7: assert property (@(posedge clk) disable iff (rst)
    seed_load && step_busy |=> !step_busy)
    else $error("load did not cancel step in flight");

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(seed_load) && !rnd_valid |-> $stable(rnd_value))
    else $error("value changed without cause");

  logic unused_fixed;
  assign unused_fixed = seed_fixed;
endmodule

// File: tb/mcg_rng_tb.sv
module mcg_rng_tb;
  localparam int BINS = 10;
  localparam longint MOD = 65521;
  localparam longint MUL = 17364;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seed_load = 1'b0;
  logic [15:0] seed_in = '0;
  logic        step_req = 1'b0;
  logic [15:0] rnd_value;
  logic        rnd_valid;
  logic [3:0]  rnd_bin;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string req_tag = "R1";

  always #2.5 clk = ~clk;

  mcg_rng #(.BINS(BINS)) u_dut (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_in(seed_in),
    .step_req(step_req), .rnd_value(rnd_value), .rnd_valid(rnd_valid),
    .rnd_bin(rnd_bin)
  );

  // Behavioural reference, updated on each rising edge
  longint m_val = 1;
  bit     m_pend = 0;
  bit     m_vld = 0;
  int     m_done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_val = 1; m_pend = 0; m_vld = 0;
    end else if (seed_load) begin
      m_val  = (seed_in == 0 || longint'(seed_in) >= MOD) ? 1 : longint'(seed_in);
      m_pend = 0; m_vld = 0;
    end else if (m_pend) begin
      m_val  = (m_val * MUL) % MOD;
      m_pend = 0; m_vld = 1; m_done++;
    end else begin
      m_vld = 0;
      if (step_req) m_pend = 1;
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Compare on every cycle, half a period after the edge
  always @(negedge clk) begin
    if (!rst) begin
      check(req_tag, "value", rnd_value, m_val);
      check("R2", "valid", rnd_valid, m_vld);
      check("R8", "bin", rnd_bin, ((m_val - 1) * BINS) / 65520);
      checks++;
      if (rnd_value == 0 || rnd_value >= 16'd65521) begin
        fails++;
        $display("FAIL R3 range: actual=%0d expected=1..65520", rnd_value);
      end
    end
  end

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_up();
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(bit ld, logic [15:0] sd, bit st);
    @(negedge clk);
    seed_load = ld; seed_in = sd; step_req = st;
  endtask

  task automatic load(logic [15:0] sd);
    drive(1, sd, 0);
    drive(0, 0, 0);
  endtask

  initial begin
    idle(3);
    // R1: values during reset
    check("R1", "reset value", rnd_value, 1);
    check("R1", "reset valid", rnd_valid, 0);
    drive(0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "post-reset value", rnd_value, 1);

    // R2: known first step from 1
    req_tag = "R2";
    drive(0, 0, 1);
    drive(0, 0, 0);
    @(negedge clk);
    check("R2", "first step value", rnd_value, 17364);
    check("R2", "first step valid", rnd_valid, 1);
    @(negedge clk);
    check("R2", "valid one cycle", rnd_valid, 0);

    // R2: paced steps with varying gaps
    for (int i = 0; i < 40; i++) begin
      drive(0, 0, 1);
      drive(0, 0, 0);
      idle(i % 4);
    end

    // R4: strobe held continuously, busy-cycle requests dropped
    req_tag = "R4";
    begin
      int start_done;
      start_done = m_done;
      drive(0, 0, 1);
      idle(39);
      drive(0, 0, 0);
      idle(3);
      check("R4", "steps in 40 held cycles", m_done - start_done, 20);
    end

    // R5: legal seed
    req_tag = "R5";
    load(16'd12345);
    check("R5", "seed value", rnd_value, 12345);
    check("R5", "seed valid", rnd_valid, 0);
    load(16'd65520);
    check("R5", "top seed", rnd_value, 65520);
    drive(0, 0, 1); drive(0, 0, 0); idle(2);

    // R6: illegal seeds
    req_tag = "R6";
    load(16'd0);
    check("R6", "seed 0", rnd_value, 1);
    load(16'd65521);
    check("R6", "seed 65521", rnd_value, 1);
    load(16'hFFFF);
    check("R6", "seed 65535", rnd_value, 1);

    // R7: load with step in same cycle, and load while in flight
    req_tag = "R7";
    load(16'd500);
    drive(1, 16'd777, 1);
    drive(0, 0, 0);
    idle(3);
    check("R7", "same-cycle load wins", rnd_value, 777);
    drive(0, 0, 1);
    drive(1, 16'd999, 0);
    drive(0, 0, 0);
    check("R7", "in-flight cancelled valid", rnd_valid, 0);
    idle(3);
    check("R7", "in-flight cancelled value", rnd_value, 999);

    // R9: idle holds
    req_tag = "R9";
    idle(10);
    check("R9", "idle hold", rnd_value, 999);

    // R8/R3: long run through many values
    req_tag = "R2";
    load(16'd1);
    drive(0, 0, 1);
    idle(3000);
    drive(0, 0, 0);
    idle(4);
    finish_up();
  end
endmodule